// File: doc/BRIEF.md
# Bus Slave Enumeration Command Handler

This block sits behind a packet receiver on a daisy-chained entertainment bus. It accepts one already checksum-validated packet per strobe, as a receiver address plus two command bytes, and keeps the slave's identity on the bus. That identity is the ID the master gave it, the poll bitmask, the ID currently selected by the master, whether this slave is the selected one, the enable for the next slave in the chain, the host wake line and a counter of bus re-initialisations.

When a command calls for an answer, the block builds a short reply. The reply is a destination address, a source address, two command bytes and an additive checksum. It hands the reply to the transmitter with a one-cycle strobe. It also emits one-cycle pulses that tell the neighbouring display and break-timing logic to clear their state.

Top module: `bus_enum_slave`

## Requirements
- R1: A packet with first command byte 0x01 and second command byte 0x00 (bus reset) clears the own ID, the current ID, the selected flag and the chain enable. It raises `disp_clr` and `brk_clr` for one cycle, increments `reinit_cnt` (wrapping at its width) and produces no reply.
- R2: A packet with first command byte 0x02 (ID offer) is ignored while a nonzero own ID is held: the ID, the bitmask and the chain enable keep their values and no reply is produced.
- R3: An ID offer is accepted only when the upper nibble of the receiver address is 0xD; otherwise it is ignored.
- R4: On acceptance, the receiver address becomes `own_id` and the second command byte becomes `poll_mask`, both one cycle after the strobe.
- R5: On acceptance, a reply {0x10, new ID, 0x8C, 0x10} is strobed one cycle after the packet, and `cascade_en` rises one cycle after that reply strobe.
- R6: On a select packet (first command byte 0xF0), the second command byte is always stored as `cur_id`. `selected` is set when that byte equals a nonzero own ID and is cleared otherwise.
- R7: On a power packet (first command byte 0x87), `host_wake` takes the value of bit 3 of the second command byte.
- R8: On a power packet whose second command byte has bit 7 clear, `selected` is cleared and `disp_clr` pulses; with bit 7 set, `selected` is kept and `disp_clr` stays low.
- R9: A packet 0x01/0x02 (open poll) received while no ID is held produces the reply {0x10, 0xD0, 0x8C, 0x10}. While an ID is held, it produces nothing.
- R10: A packet 0x01/0x12 whose receiver address equals a nonzero own ID (status poll) produces the reply {dest, own ID, 0x00, poll_mask}. The destination is 0x70 when `disp_en` is high and 0x10 otherwise.
- R11: Every reply carries `rep_sum` equal to the 8-bit sum of its four header bytes.
- R12: After reset all state outputs are zero and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_vld | input | 1 | One-cycle strobe: validated packet present |
| pkt_rad | input | 8 | Receiver address of the packet |
| pkt_cmd1 | input | 8 | First command byte |
| pkt_cmd2 | input | 8 | Second command byte |
| disp_en | input | 1 | Display feature active; status replies go to the display group |
| own_id | output | 8 | Assigned bus ID, zero when none |
| poll_mask | output | 8 | Poll bitmask stored at assignment |
| cur_id | output | 8 | ID most recently selected by the master |
| selected | output | 1 | This slave is the selected one |
| cascade_en | output | 1 | Enable for the next slave in the chain |
| host_wake | output | 1 | Head unit power state for the host |
| reinit_cnt | output | CNT_W | Bus reset count |
| disp_clr | output | 1 | One-cycle pulse: clear display state |
| brk_clr | output | 1 | One-cycle pulse: restart break timing |
| rep_vld | output | 1 | One-cycle strobe: reply ready |
| rep_rad | output | 8 | Reply destination address |
| rep_tad | output | 8 | Reply source address |
| rep_cmd1 | output | 8 | Reply first command byte |
| rep_cmd2 | output | 8 | Reply second command byte |
| rep_sum | output | 8 | Reply checksum |

## Verification
Every state output, the reply fields, the reply strobe and the two clear pulses are due one clock after the packet strobe. Only `cascade_en` lags by a second clock. The bench drives a packet at a falling edge, compares all first-cycle results at the next falling edge, and then checks the chain enable and the absence of any strobe one falling edge later. A bench model updated in the same order supplies every expected value for the seeded random packets and for the directed corner cases.

// File: rtl/bus_enum_slave.sv
module bus_enum_slave #(
  parameter int          CNT_W     = 8,
  parameter logic [3:0]  GROUP     = 4'hD,
  parameter logic [7:0]  MASTER_AD = 8'h10,
  parameter logic [7:0]  DISP_AD   = 8'h70,
  parameter logic [7:0]  ACK_CMD   = 8'h8C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_vld,
  input  logic [7:0]       pkt_rad,
  input  logic [7:0]       pkt_cmd1,
  input  logic [7:0]       pkt_cmd2,
  input  logic             disp_en,
  output logic [7:0]       own_id,
  output logic [7:0]       poll_mask,
  output logic [7:0]       cur_id,
  output logic             selected,
  output logic             cascade_en,
  output logic             host_wake,
  output logic [CNT_W-1:0] reinit_cnt,
  output logic             disp_clr,
  output logic             brk_clr,
  output logic             rep_vld,
  output logic [7:0]       rep_rad,
  output logic [7:0]       rep_tad,
  output logic [7:0]       rep_cmd1,
  output logic [7:0]       rep_cmd2,
  output logic [7:0]       rep_sum
);

  localparam logic [7:0] UNASSIGNED_AD = {GROUP, 4'h0};

  logic has_id;
  logic is_rst, is_any, is_stat, is_offer, is_asg, is_pwr, is_sel;
  logic cas_pend;

  assign has_id   = (own_id != 8'h00);
  assign is_rst   = pkt_vld && pkt_cmd1 == 8'h01 && pkt_cmd2 == 8'h00;
  assign is_any   = pkt_vld && pkt_cmd1 == 8'h01 && pkt_cmd2 == 8'h02 && !has_id;
  assign is_stat  = pkt_vld && pkt_cmd1 == 8'h01 && pkt_cmd2 == 8'h12 && has_id && pkt_rad == own_id;
  assign is_offer = pkt_vld && pkt_cmd1 == 8'h02;
  assign is_asg   = is_offer && !has_id && pkt_rad[7:4] == GROUP;
  assign is_pwr   = pkt_vld && pkt_cmd1 == 8'h87;
  assign is_sel   = pkt_vld && pkt_cmd1 == 8'hF0;

  logic       nx_go;
  logic [7:0] nx_rad, nx_tad, nx_c1, nx_c2;
  logic [7:0] acc1, acc2, acc3;

  always_comb begin
    nx_go  = 1'b0;
    nx_rad = MASTER_AD;
    nx_tad = 8'h00;
    nx_c1  = 8'h00;
    nx_c2  = 8'h00;
    if (is_asg) begin
      nx_go  = 1'b1;
      nx_tad = pkt_rad;
      nx_c1  = ACK_CMD;
      nx_c2  = MASTER_AD;
    end else if (is_any) begin
      nx_go  = 1'b1;
      nx_tad = UNASSIGNED_AD;
      nx_c1  = ACK_CMD;
      nx_c2  = MASTER_AD;
    end else if (is_stat) begin
      nx_go  = 1'b1;
      nx_rad = disp_en ? DISP_AD : MASTER_AD;
      nx_tad = own_id;
      nx_c2  = poll_mask;
    end
  end

  assign acc1 = nx_rad + nx_tad;
  assign acc2 = acc1 + nx_c1;
  assign acc3 = acc2 + nx_c2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_id     <= '0;
      poll_mask  <= '0;
      cur_id     <= '0;
      selected   <= 1'b0;
      cas_pend   <= 1'b0;
      cascade_en <= 1'b0;
      host_wake  <= 1'b0;
      reinit_cnt <= '0;
      disp_clr   <= 1'b0;
      brk_clr    <= 1'b0;
      rep_vld    <= 1'b0;
      rep_rad    <= '0;
      rep_tad    <= '0;
      rep_cmd1   <= '0;
      rep_cmd2   <= '0;
      rep_sum    <= '0;
    end else begin
      disp_clr <= 1'b0;
      brk_clr  <= 1'b0;
      rep_vld  <= nx_go;
      cas_pend <= 1'b0;
      if (cas_pend) cascade_en <= 1'b1;
      if (nx_go) begin
        rep_rad  <= nx_rad;
        rep_tad  <= nx_tad;
        rep_cmd1 <= nx_c1;
        rep_cmd2 <= nx_c2;
        rep_sum  <= acc3;
      end
      if (is_rst) begin
        own_id     <= '0;
        cur_id     <= '0;
        selected   <= 1'b0;
        cascade_en <= 1'b0;
        disp_clr   <= 1'b1;
        brk_clr    <= 1'b1;
        reinit_cnt <= reinit_cnt + 1'b1;
      end
      if (is_asg) begin
        own_id    <= pkt_rad;
        poll_mask <= pkt_cmd2;
        cas_pend  <= 1'b1;
      end
      if (is_sel) begin
        cur_id   <= pkt_cmd2;
        selected <= has_id && pkt_cmd2 == own_id;
      end
      if (is_pwr) begin
        host_wake <= pkt_cmd2[3];
        if (!pkt_cmd2[7]) begin
          selected <= 1'b0;
          disp_clr <= 1'b1;
        end
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    is_rst |=> (own_id == 8'h00 && !cascade_en && !selected && !rep_vld && brk_clr)); // R1
  AST_ID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_offer && has_id) |=> ($stable(own_id) && $stable(poll_mask) && !rep_vld)); // R2
  AST_WRONG_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_offer && !has_id && pkt_rad[7:4] != GROUP) |=> (own_id == 8'h00)); // R3
  AST_CASCADE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cascade_en) |-> $past(rep_vld)); // R5
  AST_CASCADE_NEEDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_en |-> (own_id != 8'h00)); // R5
  AST_SEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> (cur_id == own_id && own_id != 8'h00)); // R6
  AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    is_pwr |=> (host_wake == $past(pkt_cmd2[3]))); // R7
  AST_REPLY_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    rep_vld |-> (rep_sum == 8'(rep_rad + rep_tad + rep_cmd1 + rep_cmd2))); // R11

endmodule

// File: tb/sim_bus_enum_slave.sv
module sim_bus_enum_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_vld = 1'b0;
  logic [7:0] pkt_rad = '0, pkt_cmd1 = '0, pkt_cmd2 = '0;
  logic disp_en = 1'b0;
  logic [7:0] own_id, poll_mask, cur_id;
  logic selected, cascade_en, host_wake, disp_clr, brk_clr, rep_vld;
  logic [7:0] reinit_cnt;
  logic [7:0] rep_rad, rep_tad, rep_cmd1, rep_cmd2, rep_sum;

  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_enum_slave u0 (
    .clk(clk), .rst_n(rst_n), .pkt_vld(pkt_vld), .pkt_rad(pkt_rad),
    .pkt_cmd1(pkt_cmd1), .pkt_cmd2(pkt_cmd2), .disp_en(disp_en),
    .own_id(own_id), .poll_mask(poll_mask), .cur_id(cur_id), .selected(selected),
    .cascade_en(cascade_en), .host_wake(host_wake), .reinit_cnt(reinit_cnt),
    .disp_clr(disp_clr), .brk_clr(brk_clr), .rep_vld(rep_vld), .rep_rad(rep_rad),
    .rep_tad(rep_tad), .rep_cmd1(rep_cmd1), .rep_cmd2(rep_cmd2), .rep_sum(rep_sum));

  logic [7:0] m_id, m_mask, m_cur, m_cnt;
  logic m_sel, m_cas, m_wake;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sum4(logic [7:0] a, b, c, d);
    return 8'(a + b + c + d);
  endfunction

  task automatic send(logic [7:0] rad, logic [7:0] c1, logic [7:0] c2, logic de);
    logic rst_c, any_c, stat_c, asg_c, go, dclr, cas_before;
    logic [7:0] er, et, e1, e2;
    rst_c  = (c1 == 8'h01 && c2 == 8'h00);
    any_c  = (c1 == 8'h01 && c2 == 8'h02 && m_id == 0);
    stat_c = (c1 == 8'h01 && c2 == 8'h12 && m_id != 0 && rad == m_id);
    asg_c  = (c1 == 8'h02 && m_id == 0 && rad[7:4] == 4'hD);
    go = 0; dclr = 0; er = 0; et = 0; e1 = 0; e2 = 0;
    if (asg_c)       begin go = 1; er = 8'h10; et = rad;   e1 = 8'h8C; e2 = 8'h10; end
    else if (any_c)  begin go = 1; er = 8'h10; et = 8'hD0; e1 = 8'h8C; e2 = 8'h10; end
    else if (stat_c) begin go = 1; er = de ? 8'h70 : 8'h10; et = m_id; e1 = 8'h00; e2 = m_mask; end
    if (rst_c) begin m_id = 0; m_cur = 0; m_sel = 0; m_cas = 0; dclr = 1; m_cnt = m_cnt + 1; end
    cas_before = m_cas;
    if (asg_c) begin m_id = rad; m_mask = c2; m_cas = 1; end
    if (c1 == 8'hF0) begin m_sel = (m_id != 0 && c2 == m_id); m_cur = c2; end
    if (c1 == 8'h87) begin
      m_wake = c2[3];
      if (!c2[7]) begin m_sel = 0; dclr = 1; end
    end
    pkt_rad = rad; pkt_cmd1 = c1; pkt_cmd2 = c2; disp_en = de; pkt_vld = 1;
    @(negedge clk);
    pkt_vld = 0;
    chk("R4 own_id", own_id, m_id);
    chk("R4 poll_mask", poll_mask, m_mask);
    chk("R6 cur_id", cur_id, m_cur);
    chk("R6 R8 selected", selected, m_sel);
    chk("R7 host_wake", host_wake, m_wake);
    chk("R1 reinit_cnt", reinit_cnt, m_cnt);
    chk("R1 brk_clr", brk_clr, rst_c);
    chk("R1 R8 disp_clr", disp_clr, dclr);
    chk("R2 R9 R10 rep_vld", rep_vld, go);
    chk("R5 cascade early", cascade_en, rst_c ? 1'b0 : cas_before);
    if (go) begin
      chk("R5 R10 rep_rad", rep_rad, er);
      chk("R5 R9 rep_tad", rep_tad, et);
      chk("R9 rep_cmd1", rep_cmd1, e1);
      chk("R10 rep_cmd2", rep_cmd2, e2);
      chk("R11 rep_sum", rep_sum, sum4(er, et, e1, e2));
    end
    @(negedge clk);
    chk("R5 cascade_en", cascade_en, m_cas);
    chk("R5 strobe one cycle", rep_vld, 1'b0);
    chk("R1 pulse one cycle", {disp_clr, brk_clr}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_id = 0; m_mask = 0; m_cur = 0; m_cnt = 0; m_sel = 0; m_cas = 0; m_wake = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset state", {own_id, poll_mask, cur_id, selected, cascade_en, host_wake,
        reinit_cnt, disp_clr, brk_clr, rep_vld}, 0);
    send(8'h00, 8'h01, 8'h02, 0);  // R9 open poll, no ID
    send(8'h35, 8'h02, 8'h40, 0);  // R3 wrong group
    send(8'hD3, 8'h02, 8'h40, 0);  // R4 R5 accepted
    send(8'hD7, 8'h02, 8'h22, 0);  // R2 already held
    send(8'h00, 8'h01, 8'h02, 0);  // R9 open poll with ID
    send(8'hD3, 8'h01, 8'h12, 0);  // R10 to master
    send(8'hD3, 8'h01, 8'h12, 1);  // R10 to display group
    send(8'hD4, 8'h01, 8'h12, 1);  // R10 other address
    send(8'h00, 8'hF0, 8'hD3, 0);  // R6 select me
    send(8'h00, 8'h87, 8'h88, 0);  // R7 R8 on, keep
    send(8'h00, 8'h87, 8'h22, 0);  // R8 off, deselect
    send(8'h00, 8'hF0, 8'hD3, 0);
    send(8'h00, 8'hF0, 8'hD5, 0);  // R6 select other
    send(8'h00, 8'h01, 8'h00, 0);  // R1 bus reset
    send(8'h00, 8'hF0, 8'h00, 0);  // R6 zero never selects
    for (int i = 0; i < 600; i++) begin
      logic [7:0] rad, c1, c2;
      int k;
      k = $urandom_range(0, 7);
      rad = $urandom_range(0, 1) ? {4'hD, 4'($urandom_range(0, 15))} : 8'($urandom);
      c2 = 8'($urandom);
      case (k)
        0: begin c1 = 8'h01; c2 = 8'h00; end
        1: begin c1 = 8'h01; c2 = 8'h02; end
        2: begin c1 = 8'h01; c2 = 8'h12; if ($urandom_range(0, 1)) rad = m_id; end
        3: c1 = 8'h02;
        4: c1 = 8'h87;
        5: begin c1 = 8'hF0; if ($urandom_range(0, 1)) c2 = m_id; end
        default: c1 = 8'($urandom);
      endcase
      send(rad, c1, c2, 1'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule